// File: doc/BRIEF.md
# Phase-Stepped Feedback Oscillator Bank

This block produces three square waves from one shared phase tick. Each wave comes from a two-stage feedback loop. On every tick the first stage loads the activation signal ANDed with the inverse of the loop output, and the second stage loads the first stage. The loop output is the second stage. No counter is involved, so a loop that stays enabled settles into a period of four ticks: high for two ticks, then low for two.

The three outputs differ only in what drives their activation:
- The gated output follows an external activation input.
- The free-running output has its activation fixed at one.
- The triggered output waits for the first rising edge of a trigger input. A latch captures that edge, and a parameterised tap delay line passes it on to the loop. From then on the triggered output runs until reset.

All state moves only on cycles where the phase tick is high. A synchronous reset clears every stage.

Top module: `phase_osc_bank`

## Requirements
- R1: All three outputs change only on clock edges where `phase_tick` is 1; on other edges every output holds its value.
- R2: On each tick, the value of `osc_gated` after the tick equals `run_en` as sampled at the previous tick, ANDed with the inverse of `osc_gated` as it was two ticks earlier. With `run_en` held at 1, the output repeats high for 2 ticks, then low for 2 ticks.
- R3: When `run_en` rises from an idle loop, `osc_gated` goes high after the second tick that samples `run_en` high.
- R4: After `run_en` falls, `osc_gated` is 0 no later than the second tick that samples it low, and it stays 0 while `run_en` stays low.
- R5: `osc_free` runs from reset with no input. It is 0 after the first tick and 1 after the second tick, and then follows the 2-high, 2-low pattern. It is never high for three consecutive ticks.
- R6: `osc_trig` stays 0 until a tick samples `trig_in` at 1 after the previous tick sampled it at 0. The first tick after reset treats the earlier sample as 0.
- R7: The triggered output first goes high after tick number TRIG_DELAY+3, counting the tick that captures the rising edge as tick 1. This is tick 7 at the default TRIG_DELAY=4.
- R8: Once the trigger edge has been captured, `osc_trig` keeps the 2-high, 2-low pattern whatever `trig_in` does later. Only reset stops it.
- R9: A clock edge with `rst` at 1 clears all loop, latch and delay state, so all three outputs read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_tick | input | 1 | Phase step enable; state advances only when high |
| run_en | input | 1 | Activation for the gated loop |
| trig_in | input | 1 | Trigger whose first rising edge starts the triggered loop |
| osc_gated | output | 1 | Square wave gated by `run_en` |
| osc_free | output | 1 | Free-running square wave |
| osc_trig | output | 1 | Square wave started by the trigger edge |

## Verification
The properties assume that reset is applied at time zero, before any tick arrives. They assume that inputs are stable across the clock edge. They also assume that `run_en` and `trig_in` are sampled only through the tick. The stimulus changes inputs only at the falling clock edge. It opens every run with several reset cycles and pulses reset only from the bench's own reset task. Random tick density, activation runs and rare trigger pulses keep every input combination within these assumptions. The random runs still reach idle gaps, early deactivation and repeated triggers.

// File: rtl/phase_osc_pkg.sv
package phase_osc_pkg;

    // Two-stage feedback loop state: stage one feeds stage two, stage two is the output
    typedef struct packed {
        logic stage1;
        logic stage2;
    } loop_state_t;

    // Rising-edge capture state
    typedef struct packed {
        logic trig_prev;
        logic caught;
    } latch_state_t;

    localparam int LOOP_STAGES = 2;

endpackage

// File: rtl/osc_feedback_loop.sv
module osc_feedback_loop
    import phase_osc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic enable,
    output logic wave
);

    loop_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.stage1 = enable & ~st_q.stage2;
            st_d.stage2 = st_q.stage1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wave = st_q.stage2;

endmodule

// File: rtl/osc_rise_latch.sv
module osc_rise_latch
    import phase_osc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic sense,
    output logic armed
);

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.trig_prev = sense;
            st_d.caught    = st_q.caught | (sense & ~st_q.trig_prev);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign armed = st_q.caught;

endmodule

// File: rtl/osc_tap_delay.sv
module osc_tap_delay #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic din,
    output logic dout
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_line
            logic [DEPTH-1:0] taps_d, taps_q;

            always_comb begin
                taps_d = taps_q;
                if (step) begin
                    taps_d[0] = din;
                    for (int i = 1; i < DEPTH; i++) taps_d[i] = taps_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) taps_q <= '0;
                else     taps_q <= taps_d;
            end

            assign dout = taps_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/phase_osc_bank.sv
module phase_osc_bank #(
    parameter int TRIG_DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_tick,
    input  logic run_en,
    input  logic trig_in,
    output logic osc_gated,
    output logic osc_free,
    output logic osc_trig
);

    localparam int NUM_LOOPS = 3;
    localparam int IDX_GATED = 0;
    localparam int IDX_FREE  = 1;
    localparam int IDX_TRIG  = 2;

    logic                 trig_armed;
    logic                 trig_enable;
    logic [NUM_LOOPS-1:0] loop_en;
    logic [NUM_LOOPS-1:0] loop_wave;

    osc_rise_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .step  (phase_tick),
        .sense (trig_in),
        .armed (trig_armed)
    );

    osc_tap_delay #(.DEPTH(TRIG_DELAY)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .step (phase_tick),
        .din  (trig_armed),
        .dout (trig_enable)
    );

    always_comb begin
        loop_en            = '0;
        loop_en[IDX_GATED] = run_en;
        loop_en[IDX_FREE]  = 1'b1;
        loop_en[IDX_TRIG]  = trig_enable;
    end

    generate
        for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
            osc_feedback_loop u_loop (
                .clk    (clk),
                .rst    (rst),
                .step   (phase_tick),
                .enable (loop_en[g]),
                .wave   (loop_wave[g])
            );
        end
    endgenerate

    assign osc_gated = loop_wave[IDX_GATED];
    assign osc_free  = loop_wave[IDX_FREE];
    assign osc_trig  = loop_wave[IDX_TRIG];

endmodule

// File: rtl/phase_osc_bank_checker.sv
module phase_osc_bank_checker (
    input logic clk,
    input logic rst,
    input logic phase_tick,
    input logic run_en,
    input logic trig_in,
    input logic osc_gated,
    input logic osc_free,
    input logic osc_trig
);

    logic en_last_q, free_last_q, trig_last_q, rise_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_last_q   <= 1'b0;
            free_last_q <= 1'b0;
            trig_last_q <= 1'b0;
            rise_seen_q <= 1'b0;
        end else if (phase_tick) begin
            en_last_q   <= run_en;
            free_last_q <= osc_free;
            trig_last_q <= trig_in;
            rise_seen_q <= rise_seen_q | (trig_in & ~trig_last_q);
        end
    end

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
        !phase_tick |=> $stable({osc_gated, osc_free, osc_trig})); // R1

    AST_GATED_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && !en_last_q) |=> !osc_gated); // R4

    AST_FREE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && osc_free && free_last_q) |=> !osc_free); // R5

    AST_TRIG_WAITS: assert property (@(posedge clk) disable iff (rst)
        !rise_seen_q |-> !osc_trig); // R6

endmodule

bind phase_osc_bank phase_osc_bank_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .phase_tick (phase_tick),
    .run_en     (run_en),
    .trig_in    (trig_in),
    .osc_gated  (osc_gated),
    .osc_free   (osc_free),
    .osc_trig   (osc_trig)
);

// File: tb/tb_phase_osc_bank.sv
`timescale 1ns/1ps
module tb_phase_osc_bank;

    localparam int TRIG_DELAY = 4;
    localparam int HIST       = TRIG_DELAY + 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, phase_tick = 1'b0, run_en = 1'b0, trig_in = 1'b0;
    logic osc_gated, osc_free, osc_trig;

    int checks = 0;
    int errors = 0;

    phase_osc_bank #(.TRIG_DELAY(TRIG_DELAY)) dut (
        .clk(clk), .rst(rst), .phase_tick(phase_tick), .run_en(run_en),
        .trig_in(trig_in), .osc_gated(osc_gated), .osc_free(osc_free),
        .osc_trig(osc_trig)
    );

    // Reference state: previous-tick activation and the last two outputs per wave
    logic g_pen, g_o2, g_o1;
    logic f_pen, f_o2, f_o1;
    logic t_prev, t_lat, e_o2, e_o1;
    logic [HIST-1:0] lat_hist;

    function automatic logic next_wave(logic en_prev, logic out_two_back);
        return en_prev & ~out_two_back;
    endfunction

    task automatic chk(input logic cond, input string tag, input logic act, input logic exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        g_pen = 0; g_o2 = 0; g_o1 = 0;
        f_pen = 0; f_o2 = 0; f_o1 = 0;
        t_prev = 0; t_lat = 0; e_o2 = 0; e_o1 = 0;
        lat_hist = '0;
    endtask

    task automatic model_tick(input logic a, input logic t);
        logic n;
        n = next_wave(g_pen, g_o2); g_o2 = g_o1; g_o1 = n; g_pen = a;
        n = next_wave(f_pen, f_o2); f_o2 = f_o1; f_o1 = n; f_pen = 1'b1;
        n = next_wave(lat_hist[HIST-1], e_o2); e_o2 = e_o1; e_o1 = n;
        t_lat = t_lat | (t & ~t_prev);
        t_prev = t;
        lat_hist = {lat_hist[HIST-2:0], t_lat};
    endtask

    // One clock: drive at falling edge, model and compare at the next falling edge
    task automatic cyc(input logic r, input logic tk, input logic a, input logic t);
        logic pg, pf, pt;
        pg = osc_gated; pf = osc_free; pt = osc_trig;
        rst = r; phase_tick = tk; run_en = a; trig_in = t;
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            model_reset();
            chk({osc_gated, osc_free, osc_trig} == 3'b000, "R9 reset clears", osc_gated | osc_free | osc_trig, 1'b0);
        end else if (tk) begin
            model_tick(a, t);
        end else begin
            chk({osc_gated, osc_free, osc_trig} == {pg, pf, pt}, "R1 hold without tick", osc_gated, pg);
        end
        chk(osc_gated == g_o1, "R2 gated wave", osc_gated, g_o1);
        chk(osc_free  == f_o1, "R5 free wave",  osc_free,  f_o1);
        chk(osc_trig  == e_o1, "R8 trig wave",  osc_trig,  e_o1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat7;
        int highs;
        void'($urandom(32'h5eed_0c11));
        model_reset();
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);

        // R3 and R5: activation from idle
        cyc(0, 1, 1, 0);
        chk(osc_gated == 1'b0, "R3 low after first tick", osc_gated, 1'b0);
        chk(osc_free == 1'b0, "R5 free low after tick 1", osc_free, 1'b0);
        cyc(0, 1, 1, 0);
        chk(osc_gated == 1'b1, "R3 high after second tick", osc_gated, 1'b1);
        chk(osc_free == 1'b1, "R5 free high after tick 2", osc_free, 1'b1);
        for (int i = 0; i < 8; i++) cyc(0, 1, 1, 0);

        // R1: idle gaps between ticks
        for (int i = 0; i < 6; i++) cyc(0, i % 2, 1, 0);

        // R4: deactivation
        cyc(0, 1, 0, 0);
        cyc(0, 1, 0, 0);
        chk(osc_gated == 1'b0, "R4 low by second idle tick", osc_gated, 1'b0);
        for (int i = 0; i < 6; i++) begin
            cyc(0, 1, 0, 0);
            chk(osc_gated == 1'b0, "R4 stays low", osc_gated, 1'b0);
        end

        // R6: no trigger edge, triggered output quiet
        for (int i = 0; i < 20; i++) begin
            cyc(0, 1, 0, 0);
            chk(osc_trig == 1'b0, "R6 quiet before edge", osc_trig, 1'b0);
        end

        // R7: latency from the capturing tick
        lat7 = 0;
        for (int i = 1; i <= 12; i++) begin
            cyc(0, 1, 0, (i <= 2) ? 1'b1 : 1'b0);
            if (osc_trig && lat7 == 0) lat7 = i;
        end
        chk(lat7 == TRIG_DELAY + 3, "R7 trigger latency", lat7[0], 1'b1);
        if (lat7 != TRIG_DELAY + 3) $display("FAIL R7: actual %0d expected %0d", lat7, TRIG_DELAY + 3);

        // R8: keeps running whatever the trigger does
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            cyc(0, 1, 0, i[1]);
            highs += osc_trig;
        end
        chk(highs == 8, "R8 runs after trigger", highs[3], 1'b1);
        if (highs != 8) $display("FAIL R8: actual %0d expected 8 highs", highs);

        // R9: reset mid-run, trigger held high across reset counts as a fresh edge (R6)
        cyc(1, 1, 1, 1);
        cyc(1, 0, 1, 1);
        for (int i = 0; i < 10; i++) cyc(0, 1, 1, 1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic r, tk, a, t;
            r  = ($urandom_range(0, 199) == 0);
            tk = ($urandom_range(0, 9) < 7);
            a  = ($urandom_range(0, 9) < 8) ? run_en : ~run_en;
            t  = ($urandom_range(0, 49) == 0) ? ~trig_in : trig_in;
            cyc(r, tk, a, t);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule